// File: doc/BRIEF.md
# Monitor-Line Interrupt Controller

This block watches a 12-bit vector of configuration monitor lines coming from a programmable-logic fabric and turns changes on them into a single interrupt request for a host processor. Each line passes through a synchroniser first. Each line can then be set on its own to level or edge detection, to active-high or active-low, and to enabled or disabled, masked or unmasked. The host sees every line through the same 32-bit register bus. Here it programs the four configuration registers, reads the raw and masked status, acknowledges latched edges, and samples the live line values.

The monitor bit layout is the same in every register:

| Bit | Line |
|---|---|
| 0 | active-low fabric status |
| 1 | configuration done |
| 2 | initialisation done |
| 3 | CRC error |
| 4 | alternate-path configuration done |
| 5 | partial-region ready |
| 6 | partial-region error |
| 7 | partial-region done |
| 8 | configuration request pin |
| 9 | status pin |
| 10 | configuration-done pin |
| 11 | fabric power good |

A typical use is the wait for configuration done. Software sets bit 1 to level mode with active-high polarity, unmasks it and enables it, and then waits on the interrupt line.

Top module: `mon_irq_ctrl`

The register window uses fixed offsets:

| Offset | Register | Access |
|---|---|---|
| 0x830 | enable | read/write |
| 0x834 | mask | read/write |
| 0x838 | trigger kind | read/write |
| 0x83c | polarity | read/write |
| 0x840 | masked status | read-only |
| 0x844 | raw status | read-only |
| 0x84c | end-of-interrupt | write-only |
| 0x850 | synchronised line values | read-only |

Every register uses bits 11:0. Bit i of every register refers to `mon_i[i]`.

## Requirements
- R1: After reset, the enable, mask, trigger-kind and polarity registers read 0, and `irq_o` is 0.
- R2: The enable, mask, trigger-kind and polarity registers store bits 11:0 of a write. They read those bits back with bits 31:12 as 0.
- R3: A read of 0x850 returns `mon_i` delayed by the two synchroniser stages in bits 11:0, with zeros above.
- R4: When a trigger-kind bit is 0, the line is level-sensitive. Its raw status bit (0x844) is 1 exactly while the synchronised line equals its polarity bit. Polarity 1 means active high and polarity 0 means active low.
- R5: When a trigger-kind bit is 1, the raw status bit sets on a synchronised transition toward the active level: rising for polarity 1, falling for polarity 0. It stays set after the line returns to the inactive level.
- R6: A write to 0x84c clears every latched edge bit whose write-data bit is 1 and leaves the other bits unchanged. A read of 0x84c returns 0.
- R7: A read of 0x840 returns raw status AND enable AND NOT mask.
- R8: `irq_o` is 1 exactly when any bit of the masked status is 1. With enable at 0 it stays 0.
- R9: Writes to the read-only offsets and to unmapped offsets change no register. Reads of unmapped offsets return 0.
- R10: Setting a trigger-kind bit to 0 discards any edge latched on that line. Returning it to 1 does not bring the discarded edge back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| mon_i | input | 12 | Asynchronous monitor lines |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench walks every line through both polarities in level mode and checks raw status against an arithmetic comparison of line and polarity. A swapped polarity sense would invert every raw bit. The edge sweep sets lines one by one and then drops them again, expecting the latched bits to pile up. A design that reported the live level in edge mode, or latched the wrong direction, would lose bits there. Partial end-of-interrupt patterns catch a clear that ignores the data bits. A trigger-kind round trip catches a latch that survives level mode. Writes to status and unmapped offsets must leave the configuration untouched.

// File: rtl/mon_irq_pkg.sv
package mon_irq_pkg;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam logic [11:0] OFS_ENABLE = 12'h830;
    localparam logic [11:0] OFS_MASK   = 12'h834;
    localparam logic [11:0] OFS_KIND   = 12'h838;
    localparam logic [11:0] OFS_POLAR  = 12'h83c;
    localparam logic [11:0] OFS_MSTAT  = 12'h840;
    localparam logic [11:0] OFS_RAW    = 12'h844;
    localparam logic [11:0] OFS_ACK    = 12'h84c;
    localparam logic [11:0] OFS_PORT   = 12'h850;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_MASK,
        SEL_KIND,
        SEL_POLAR,
        SEL_MSTAT,
        SEL_RAW,
        SEL_ACK,
        SEL_PORT
    } reg_sel_e;

endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/mon_irq_cell.sv
module mon_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic kind_i,
    input  logic polar_i,
    input  logic ack_i,
    output logic raw_o
);

    typedef struct packed {
        logic prev;
        logic latched;
    } cell_t;

    cell_t st_d, st_q;
    logic  edge_hit;

    always_comb begin
        edge_hit = polar_i ? (line_i & ~st_q.prev) : (~line_i & st_q.prev);
        st_d.prev = line_i;
        if (!kind_i)       st_d.latched = 1'b0;
        else if (edge_hit) st_d.latched = 1'b1;
        else if (ack_i)    st_d.latched = 1'b0;
        else               st_d.latched = st_q.latched;
        raw_o = kind_i ? st_q.latched : ~(line_i ^ polar_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_edge_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i && st_q.latched && !ack_i) |=> st_q.latched)
        else $error("latched edge dropped without acknowledge");

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i && ack_i && !edge_hit) |=> !st_q.latched)
        else $error("acknowledge did not clear latched edge");

    p_level_discards_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !kind_i |=> !st_q.latched)
        else $error("edge latch kept in level mode");

endmodule

// File: rtl/mon_irq_ctrl.sv
module mon_irq_ctrl
    import mon_irq_pkg::*;
#(
    parameter int NUM_MON     = 12,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NUM_MON-1:0] mon_i,
    output logic              irq_o
);

    localparam int PAD_W = DATA_W - NUM_MON;

    typedef struct packed {
        logic [NUM_MON-1:0] enable;
        logic [NUM_MON-1:0] mask;
        logic [NUM_MON-1:0] kind;
        logic [NUM_MON-1:0] polar;
    } cfg_t;

    cfg_t               cfg_d, cfg_q;
    reg_sel_e           sel;
    logic [NUM_MON-1:0] line_s;
    logic [NUM_MON-1:0] raw;
    logic [NUM_MON-1:0] mstat;
    logic [NUM_MON-1:0] ack;
    logic [NUM_MON-1:0] rd_val;
    logic [NUM_MON-1:0] wval;

    mon_sync #(.WIDTH(NUM_MON), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mon_i),
        .sync_o  (line_s)
    );

    always_comb begin
        case (bus_addr_i)
            ADDR_W'(OFS_ENABLE): sel = SEL_ENABLE;
            ADDR_W'(OFS_MASK):   sel = SEL_MASK;
            ADDR_W'(OFS_KIND):   sel = SEL_KIND;
            ADDR_W'(OFS_POLAR):  sel = SEL_POLAR;
            ADDR_W'(OFS_MSTAT):  sel = SEL_MSTAT;
            ADDR_W'(OFS_RAW):    sel = SEL_RAW;
            ADDR_W'(OFS_ACK):    sel = SEL_ACK;
            ADDR_W'(OFS_PORT):   sel = SEL_PORT;
            default:             sel = SEL_NONE;
        endcase
    end

    always_comb begin
        wval  = bus_wdata_i[NUM_MON-1:0];
        cfg_d = cfg_q;
        if (bus_wr_i) begin
            case (sel)
                SEL_ENABLE: cfg_d.enable = wval;
                SEL_MASK:   cfg_d.mask   = wval;
                SEL_KIND:   cfg_d.kind   = wval;
                SEL_POLAR:  cfg_d.polar  = wval;
                default:    ;
            endcase
        end
        ack = (bus_wr_i && sel == SEL_ACK) ? wval : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    generate
        for (genvar b = 0; b < NUM_MON; b++) begin : g_cell
            mon_irq_cell cell_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .line_i  (line_s[b]),
                .kind_i  (cfg_q.kind[b]),
                .polar_i (cfg_q.polar[b]),
                .ack_i   (ack[b]),
                .raw_o   (raw[b])
            );
        end
    endgenerate

    always_comb begin
        mstat = raw & cfg_q.enable & ~cfg_q.mask;
        irq_o = |mstat;
        case (sel)
            SEL_ENABLE: rd_val = cfg_q.enable;
            SEL_MASK:   rd_val = cfg_q.mask;
            SEL_KIND:   rd_val = cfg_q.kind;
            SEL_POLAR:  rd_val = cfg_q.polar;
            SEL_MSTAT:  rd_val = mstat;
            SEL_RAW:    rd_val = raw;
            SEL_PORT:   rd_val = line_s;
            default:    rd_val = '0;
        endcase
        bus_rdata_o = {{PAD_W{1'b0}}, rd_val};
    end

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cfg_q.enable != '0))
        else $error("interrupt raised with all lines disabled");

    p_readonly_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && (sel == SEL_MSTAT || sel == SEL_RAW || sel == SEL_PORT ||
                      sel == SEL_NONE)) |=> $stable(cfg_q))
        else $error("configuration changed by write to read-only offset");

endmodule

// File: tb/mon_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mon_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] mon = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mon_irq_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .mon_i       (mon),
        .irq_o       (irq)
    );

    localparam logic [11:0] A_EN = 12'h830, A_MK = 12'h834, A_KD = 12'h838,
        A_PL = 12'h83c, A_MS = 12'h840, A_RW = 12'h844, A_AK = 12'h84c,
        A_PT = 12'h850;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic drive(input logic [11:0] v);
        @(negedge clk);
        mon = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] acc;
        logic [11:0] pats [6];
        pats[0] = 12'h000; pats[1] = 12'hfff; pats[2] = 12'ha5c;
        pats[3] = 12'h3c3; pats[4] = 12'h801; pats[5] = 12'h5f0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_chk("R1 enable", A_EN, 0);
        rd_chk("R1 mask", A_MK, 0);
        rd_chk("R1 kind", A_KD, 0);
        rd_chk("R1 polarity", A_PL, 0);
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R1 irq: got %b expected 0", irq); end

        // R2 readback, upper bits dropped
        for (int r = 0; r < 4; r++) begin
            logic [11:0] a;
            a = 12'h830 + 12'(4 * r);
            wr(a, 32'hffff_ffff);
            rd_chk("R2 all ones", a, 32'h0000_0fff);
            wr(a, 32'h1234_5a5c + 32'(r));
            rd_chk("R2 pattern", a, 32'h0000_0a5c + 32'(r));
            wr(a, 0);
        end

        // R9 writes to read-only / unmapped offsets
        wr(A_EN, 32'h0000_0123);
        wr(A_MS, 32'hffff_ffff);
        wr(A_RW, 32'hffff_ffff);
        wr(A_PT, 32'hffff_ffff);
        wr(12'h800, 32'hffff_ffff);
        wr(12'h848, 32'hffff_ffff);
        rd_chk("R9 enable kept", A_EN, 32'h123);
        rd_chk("R9 mask kept", A_MK, 0);
        rd_chk("R9 kind kept", A_KD, 0);
        rd_chk("R9 polarity kept", A_PL, 0);
        rd_chk("R9 unmapped read", 12'h800, 0);
        rd_chk("R9 gap read", 12'h848, 0);
        wr(A_EN, 0);

        // R3 port sweep
        for (int k = 0; k < 12; k++) begin
            drive(12'(1 << k));
            rd_chk("R3 walking one", A_PT, 32'(1 << k));
        end
        for (int p = 0; p < 6; p++) begin
            drive(pats[p]);
            rd_chk("R3 pattern", A_PT, {20'h0, pats[p]});
        end

        // R4 level mode, several polarities
        for (int q = 0; q < 4; q++) begin
            logic [11:0] pol;
            pol = (q == 0) ? 12'h000 : (q == 1) ? 12'hfff : (q == 2) ? 12'ha5a : 12'h0f0;
            wr(A_PL, {20'h0, pol});
            for (int p = 0; p < 6; p++) begin
                drive(pats[p]);
                rd_chk("R4 level raw", A_RW, {20'h0, ~(pats[p] ^ pol)});
            end
        end

        // R7 / R8 masked status and irq
        wr(A_PL, 32'hfff);
        for (int p = 0; p < 6; p++) begin
            drive(pats[p]);
            for (int c = 0; c < 4; c++) begin
                logic [11:0] en, mk, ms;
                en = (c == 0) ? 12'h000 : (c == 1) ? 12'hfff : (c == 2) ? 12'hfff : 12'h0f6;
                mk = (c == 0) ? 12'h000 : (c == 1) ? 12'h000 : (c == 2) ? pats[p] : 12'h032;
                ms = pats[p] & en & ~mk;
                wr(A_EN, {20'h0, en});
                wr(A_MK, {20'h0, mk});
                rd_chk("R7 masked status", A_MS, {20'h0, ms});
                checks++;
                if (irq !== (|ms)) begin
                    errors++;
                    $display("FAIL R8 irq: got %b expected %b", irq, |ms);
                end
            end
        end
        wr(A_EN, 0); wr(A_MK, 0);

        // R5 / R6 edge mode, rising
        drive(12'h000);
        wr(A_PL, 32'hfff);
        wr(A_KD, 32'hfff);
        wr(A_AK, 32'hfff);
        rd_chk("R6 cleared start", A_RW, 0);
        acc = '0;
        for (int i = 0; i < 12; i++) begin
            drive(12'(1 << i));
            acc = acc | 12'(1 << i);
            rd_chk("R5 rising latched", A_RW, {20'h0, acc});
            drive(12'h000);
            rd_chk("R5 held after release", A_RW, {20'h0, acc});
        end
        wr(A_AK, 32'h555);
        rd_chk("R6 partial ack", A_RW, 32'haaa);
        wr(A_AK, 32'h000);
        rd_chk("R6 zero ack", A_RW, 32'haaa);
        rd_chk("R6 ack reads zero", A_AK, 0);
        wr(A_AK, 32'hfff);
        rd_chk("R6 full ack", A_RW, 0);

        // R5 falling with active-low polarity
        drive(12'hfff);
        wr(A_PL, 0);
        wr(A_AK, 32'hfff);
        rd_chk("R5 low-active clean", A_RW, 0);
        acc = '0;
        for (int i = 0; i < 12; i++) begin
            drive(~12'(1 << i));
            acc = acc | 12'(1 << i);
            rd_chk("R5 falling latched", A_RW, {20'h0, acc});
            drive(12'hfff);
            rd_chk("R5 rising ignored", A_RW, {20'h0, acc});
        end

        // R10 level-mode round trip discards latch
        wr(A_KD, 32'hffe);
        repeat (2) @(negedge clk);
        rd_chk("R10 level mode bit0", A_RW, 32'hffe);
        wr(A_KD, 32'hfff);
        repeat (2) @(negedge clk);
        rd_chk("R10 latch not restored", A_RW, 32'hffe);

        finish_run();
    end

endmodule